// File: doc/BRIEF.md
# Paged I2C Register Slave

This block is an I2C target that lets a host microcontroller reach nine pages of registers through a single page-select register. Eight pages hold per-frame LED data (on/off bits, blink bits and one PWM byte per LED). The ninth page holds function and control registers. The block detects START and STOP, matches its device address, takes byte writes with an auto-incrementing register pointer, and serves reads after a repeated START. Register storage sits outside the block, behind a simple strobe interface with a registered read.

The host first writes the page code to register FDh. Later accesses use the selected page. A read follows three steps: select the page, write the register address, then issue a repeated START with the read bit set. Two level inputs gate access. A hardware-run input, when low, makes the block ignore the bus entirely. A software-shutdown input, when high, allows frame pages to be read back. The function page can be read in any state.

The control FSM has these states: S_IDLE, S_RX_DEV (device byte), S_ACK_DEV, S_RX_REG (register address), S_ACK_REG, S_RX_DAT (write data), S_ACK_DAT, S_TX (read byte out), S_TX_ACK (host acknowledge) and S_WAIT_STOP. Transitions:
- START in any state goes to S_RX_DEV.
- STOP in any state goes to S_IDLE.
- From S_RX_DEV, a matching address goes to S_ACK_DEV. A mismatch goes to S_IDLE.
- From S_ACK_DEV, a write goes to S_RX_REG and a read goes to S_TX.
- S_RX_REG goes to S_ACK_REG, then to S_RX_DAT.
- S_RX_DAT goes to S_ACK_DAT, then back to S_RX_DAT.
- S_TX goes to S_TX_ACK. From there, a host ACK goes back to S_TX and a host NACK goes to S_WAIT_STOP.

Top module: `i2c_paged_slave`

## Requirements
- R1: A device byte whose upper seven bits equal 1110 1 followed by strap_sel[1:0] is acknowledged (SDA pulled low during the ninth clock). Any other address is not acknowledged, and the bytes that follow it are ignored until the next START.
- R2: strap_sel[1] is address bit 2 and strap_sel[0] is address bit 1 of the device byte. Every strap code selects its own address, and the previously valid address is then refused.
- R3: Writing 00h–07h or 0Bh to register FDh selects that page. Reading FDh returns the current page code. After reset the page is 00h.
- R4: Writing any other value to FDh is acknowledged and leaves the page unchanged.
- R5: Each written data byte gives exactly one mem_we pulse, carrying the current page, the pointer and the byte. The pointer then increments by one, wrapping at 8 bits. Writes to FDh never reach mem_we.
- R6: After a repeated START with the read bit set, bytes are returned MSB first from the backing store at the pointer. The pointer increments per byte. A host NACK ends the read.
- R7: A read of a frame page (codes 00h–07h) while soft_off is low returns FFh and issues no mem_re.
- R8: The function page (code 0Bh) is readable while soft_off is low.
- R9: A read of function register 04h returns 00h without mem_re. A write to function register 04h still reaches mem_we.
- R10: A read of function register 07h raises mem_intr_clr for one cycle, together with its mem_re.
- R11: While hw_run is low, the device address is not acknowledged and no mem_we or mem_re occurs.
- R12: After reset, SDA is released and no strobe is active. A repeated START in mid-transfer restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_sel | input | 2 | Address strap bits (ground 00, supply 11, SCL 01, SDA 10) |
| hw_run | input | 1 | Low blocks all register access |
| soft_off | input | 1 | High = software shutdown; frame pages readable |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_page | output | 4 | Page code of the access |
| mem_addr | output | 8 | Register address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| mem_intr_clr | output | 1 | Pulse when function register 07h is read |

## Verification
The hardest case is reading a frame page while software shutdown is off. No internal flag shows it, so the bench reaches it only by a full three-step sequence: select page, write the register address, then repeated START with read. It then compares the returned FFh bytes and the absence of any new mem_re pulse. The same three-step route reaches the 04h and 07h corner cases. Strobe counts taken before and after each burst show which bytes came from the backing store. Bus-level cases such as a mismatched address or a hardware-disabled block are driven with raw bit-level tasks. Those tasks keep clocking bytes after the refused address, so any stray write reaches the write scoreboard.

// File: rtl/i2c_pg_pkg.sv
package i2c_pg_pkg;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 4;
    localparam logic [4:0] DEV_BASE = 5'b11101;
    localparam logic [7:0] PAGE_SEL_REG = 8'hFD;
    localparam logic [7:0] FUNC_PAGE = 8'h0B;
    localparam int unsigned FRAME_PAGES = 8;
    localparam logic [7:0] UNDEF_REG = 8'h04;
    localparam logic [7:0] IRQ_REG = 8'h07;
    localparam logic [7:0] BLOCKED_BYTE = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RX_DEV,
        S_ACK_DEV,
        S_RX_REG,
        S_ACK_REG,
        S_RX_DAT,
        S_ACK_DAT,
        S_TX,
        S_TX_ACK,
        S_WAIT_STOP
    } bus_state_t;
endpackage

// File: rtl/i2c_pg_linein.sv
module i2c_pg_linein #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_d  <= scl_q;
            sda_d  <= sda_q;
        end
    end

    assign scl_q     = scl_sh[STAGES-1];
    assign sda_q     = sda_sh[STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_pg_access.sv
module i2c_pg_access
    import i2c_pg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_run,
    input  logic              soft_off,
    input  logic              ptr_load,
    input  logic [DATA_W-1:0] ptr_val,
    input  logic              ptr_inc,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_we,
    output logic              mem_re,
    output logic [PAGE_W-1:0] mem_page,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_intr_clr
);
    logic [DATA_W-1:0] ptr;
    logic [DATA_W-1:0] page;
    logic [DATA_W-1:0] const_q;
    logic              from_mem;
    logic              rd_pend;
    logic              is_func;
    logic              sel_hit;
    logic              code_ok;

    assign is_func = (page == FUNC_PAGE);
    assign sel_hit = (ptr == PAGE_SEL_REG);
    assign code_ok = (wr_data < DATA_W'(FRAME_PAGES)) || (wr_data == FUNC_PAGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr          <= '0;
            page         <= '0;
            const_q      <= '0;
            from_mem     <= 1'b0;
            rd_pend      <= 1'b0;
            rd_valid     <= 1'b0;
            mem_we       <= 1'b0;
            mem_re       <= 1'b0;
            mem_page     <= '0;
            mem_addr     <= '0;
            mem_wdata    <= '0;
            mem_intr_clr <= 1'b0;
        end else begin
            mem_we       <= 1'b0;
            mem_re       <= 1'b0;
            mem_intr_clr <= 1'b0;
            rd_pend      <= rd_req;
            rd_valid     <= rd_pend;
            if (ptr_load) begin
                ptr <= ptr_val;
            end else if (ptr_inc) begin
                ptr <= ptr + 1'b1;
            end
            if (wr_req) begin
                if (sel_hit) begin
                    if (code_ok) begin
                        page <= wr_data;
                    end
                end else if (hw_run) begin
                    mem_we    <= 1'b1;
                    mem_page  <= page[PAGE_W-1:0];
                    mem_addr  <= ptr;
                    mem_wdata <= wr_data;
                end
            end
            if (rd_req) begin
                from_mem <= 1'b0;
                if (sel_hit) begin
                    const_q <= page;
                end else if (!hw_run) begin
                    const_q <= BLOCKED_BYTE;
                end else if (is_func && ptr == UNDEF_REG) begin
                    const_q <= '0;
                end else if (!is_func && !soft_off) begin
                    const_q <= BLOCKED_BYTE;
                end else begin
                    from_mem     <= 1'b1;
                    mem_re       <= 1'b1;
                    mem_page     <= page[PAGE_W-1:0];
                    mem_addr     <= ptr;
                    mem_intr_clr <= is_func && (ptr == IRQ_REG);
                end
            end
        end
    end

    assign rd_data = from_mem ? mem_rdata : const_q;

    p_page_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (page < DATA_W'(FRAME_PAGES)) || (page == FUNC_PAGE));
    p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    p_frame_read_shdn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mem_page != FUNC_PAGE[PAGE_W-1:0]) |-> $past(soft_off));
    p_irq_with_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_intr_clr |-> (mem_re && mem_addr == IRQ_REG && mem_page == FUNC_PAGE[PAGE_W-1:0]));
    p_no_access_hw_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> $past(hw_run));
endmodule

// File: rtl/i2c_paged_slave.sv
module i2c_paged_slave
    import i2c_pg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [1:0]        strap_sel,
    input  logic              hw_run,
    input  logic              soft_off,
    output logic              mem_we,
    output logic              mem_re,
    output logic [PAGE_W-1:0] mem_page,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_intr_clr
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    bus_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic              full;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] txreg;
    logic              is_read;
    logic              more;
    logic              scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic              addr_hit;
    logic              ptr_load, ptr_inc, wr_req, rd_req, rd_valid;
    logic [DATA_W-1:0] rd_data;

    i2c_pg_linein #(.STAGES(SYNC_STAGES)) u_linein (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign addr_hit = (shreg[DATA_W-1:1] == {DEV_BASE, strap_sel}) && hw_run;

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            full    <= 1'b0;
            shreg   <= '0;
            txreg   <= '1;
            is_read <= 1'b0;
            more    <= 1'b0;
        end else if (stop_det) begin
            state <= S_IDLE;
        end else if (start_det) begin
            state <= S_RX_DEV;
            cnt   <= '0;
            full  <= 1'b0;
        end else begin
            if (rd_valid) begin
                txreg <= rd_data;
            end
            unique case (state)
                S_IDLE, S_WAIT_STOP: begin
                end
                S_RX_DEV, S_RX_REG, S_RX_DAT: begin
                    if (scl_rise) begin
                        shreg <= {shreg[DATA_W-2:0], sda_q};
                        cnt   <= cnt + 1'b1;
                        full  <= (cnt == LAST_BIT);
                    end else if (scl_fall && full) begin
                        full <= 1'b0;
                        if (state == S_RX_DEV) begin
                            if (addr_hit) begin
                                is_read <= shreg[0];
                                state   <= S_ACK_DEV;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else if (state == S_RX_REG) begin
                            state <= S_ACK_REG;
                        end else begin
                            state <= S_ACK_DAT;
                        end
                    end
                end
                S_ACK_DEV: begin
                    if (scl_fall) begin
                        state <= is_read ? S_TX : S_RX_REG;
                        cnt   <= '0;
                    end
                end
                S_ACK_REG, S_ACK_DAT: begin
                    if (scl_fall) begin
                        state <= S_RX_DAT;
                        cnt   <= '0;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            state <= S_TX_ACK;
                        end else begin
                            txreg <= {txreg[DATA_W-2:0], 1'b1};
                            cnt   <= cnt + 1'b1;
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        more <= ~sda_q;
                    end
                    if (scl_fall) begin
                        state <= more ? S_TX : S_WAIT_STOP;
                        cnt   <= '0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs and request strobes
    always_comb begin
        sda_pull = 1'b0;
        ptr_load = 1'b0;
        ptr_inc  = 1'b0;
        wr_req   = 1'b0;
        rd_req   = 1'b0;
        unique case (state)
            S_ACK_DEV: begin
                sda_pull = 1'b1;
                rd_req   = scl_rise && is_read;
            end
            S_ACK_REG: sda_pull = 1'b1;
            S_ACK_DAT: begin
                sda_pull = 1'b1;
                ptr_inc  = scl_fall;
            end
            S_RX_REG: ptr_load = scl_fall && full;
            S_RX_DAT: wr_req   = scl_fall && full;
            S_TX: begin
                sda_pull = ~txreg[DATA_W-1];
                ptr_inc  = scl_fall && (cnt == LAST_BIT);
            end
            S_TX_ACK: rd_req = scl_rise && !sda_q;
            default: begin
            end
        endcase
    end

    i2c_pg_access u_access (
        .clk(clk), .rst_n(rst_n), .hw_run(hw_run), .soft_off(soft_off),
        .ptr_load(ptr_load), .ptr_val(shreg), .ptr_inc(ptr_inc),
        .wr_req(wr_req), .wr_data(shreg), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_we(mem_we), .mem_re(mem_re), .mem_page(mem_page),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_intr_clr(mem_intr_clr)
    );

    p_ack_needs_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK_DEV) |-> (shreg[DATA_W-1:1] == {DEV_BASE, strap_sel}));
    p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_q);
endmodule

// File: tb/i2c_paged_slave_tb.sv
module i2c_paged_slave_tb;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl;
    logic       sda_low;
    logic       sda_pull;
    logic [1:0] strap;
    logic       hw_run, soft_off;
    logic       mem_we, mem_re, mem_intr_clr;
    logic [3:0] mem_page;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic       sda_line;

    int checks = 0, failures = 0, re_cnt = 0, clr_cnt = 0;
    bit done = 0;
    logic [7:0] cur_page = 8'h00;
    logic [7:0] wbuf [8];
    logic [19:0] exp_q [$];

    always #2.5 clk = ~clk;
    assign sda_line = ~(sda_pull | sda_low);

    i2c_paged_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull),
        .strap_sel(strap), .hw_run(hw_run), .soft_off(soft_off),
        .mem_we(mem_we), .mem_re(mem_re), .mem_page(mem_page), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_intr_clr(mem_intr_clr)
    );

    function automatic logic [7:0] mem_val(input logic [3:0] p, input logic [7:0] a);
        return {p, 4'h0} ^ a ^ 8'h5A;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'hFD) return cur_page;
        if (cur_page == 8'h0B) return (a == 8'h04) ? 8'h00 : mem_val(4'hB, a);
        return soft_off ? mem_val(cur_page[3:0], a) : 8'hFF;
    endfunction

    // backing store model: registered read
    always @(posedge clk) if (mem_re) mem_rdata <= mem_val(mem_page, mem_addr);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected writes
    always @(negedge clk) begin
        if (mem_re) re_cnt++;
        if (mem_intr_clr) clr_cnt++;
        if (mem_we) begin
            if (exp_q.size() == 0) chk("R5 unexpected write", {mem_page, mem_addr, mem_wdata}, 0);
            else chk("R5 write item", {mem_page, mem_addr, mem_wdata}, exp_q.pop_front());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_low = 0; scl = 1; tick(Q); sda_low = 1; tick(Q); scl = 0; tick(Q);
    endtask
    task automatic bus_rstart();
        sda_low = 0; tick(Q); scl = 1; tick(Q); sda_low = 1; tick(Q); scl = 0; tick(Q);
    endtask
    task automatic bus_stop();
        sda_low = 1; tick(Q); scl = 1; tick(Q); sda_low = 0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_low = ~b[i]; tick(Q); scl = 1; tick(Q); scl = 0; tick(Q);
        end
        sda_low = 0; tick(Q); scl = 1; tick(Q/2); ack = ~sda_line; tick(Q/2); scl = 0; tick(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        sda_low = 0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1; tick(Q/2); b[i] = sda_line; tick(Q/2); scl = 0;
        end
        tick(2); sda_low = ack; tick(Q); scl = 1; tick(Q); scl = 0; tick(Q); sda_low = 0;
    endtask

    function automatic logic [7:0] dev(input bit rd);
        return {5'b11101, strap, rd};
    endfunction

    // driver: writes bytes and pushes the expected strobes
    task automatic do_write(input logic [7:0] ra, input int n);
        bit ack;
        bus_start();
        send_byte(dev(0), ack); chk("R1 addr ack (write)", ack, 1);
        send_byte(ra, ack);
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            a = ra + 8'(i);
            if (a == 8'hFD) begin
                if (wbuf[i] < 8'h08 || wbuf[i] == 8'h0B) cur_page = wbuf[i];
            end else begin
                exp_q.push_back({cur_page[3:0], a, wbuf[i]});
            end
            send_byte(wbuf[i], ack);
            chk("R4/R5 data ack", ack, 1);
        end
        bus_stop();
        tick(4);
    endtask

    task automatic do_read(input logic [7:0] ra, input int n, input string tag);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(dev(0), ack); chk("R1 addr ack (read setup)", ack, 1);
        send_byte(ra, ack);
        bus_rstart();
        send_byte(dev(1), ack); chk("R6 addr ack (read)", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(tag, b, exp_read(ra + 8'(i)));
        end
        bus_stop();
        tick(4);
    endtask

    initial begin
        int r0, c0;
        bit ack;
        rst_n = 0; scl = 1; sda_low = 0; strap = 2'b00; hw_run = 1; soft_off = 0;
        tick(5); rst_n = 1; tick(5);
        chk("R12 reset sda released", sda_pull, 0);
        chk("R12 reset no write", mem_we, 0);
        chk("R12 reset no read", mem_re, 0);

        do_read(8'hFD, 1, "R3 reset page");
        wbuf[0] = 8'h02; do_write(8'hFD, 1);
        do_read(8'hFD, 1, "R3 page readback");

        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        do_write(8'h24, 3);                               // R5 burst

        wbuf[0] = 8'h09; do_write(8'hFD, 1);              // R4 reserved code
        do_read(8'hFD, 1, "R4 page unchanged");

        r0 = re_cnt;
        do_read(8'h24, 2, "R7 blocked frame read");
        chk("R7 no mem_re", re_cnt - r0, 0);

        soft_off = 1; r0 = re_cnt;
        do_read(8'h30, 3, "R6 frame read burst");
        chk("R6 mem_re count", re_cnt - r0, 3);

        soft_off = 0;
        wbuf[0] = 8'h0B; do_write(8'hFD, 1);
        do_read(8'h00, 2, "R8 function read");

        c0 = clr_cnt;
        do_read(8'h06, 3, "R10 function read around 07h");
        chk("R10 clear pulse count", clr_cnt - c0, 1);

        r0 = re_cnt;
        do_read(8'h03, 3, "R9 read around 04h");
        chk("R9 mem_re count", re_cnt - r0, 2);
        wbuf[0] = 8'h5E; do_write(8'h04, 1);              // R9 write reaches store

        // R1: wrong address refused, trailing bytes ignored
        bus_start();
        send_byte({5'b11101, ~strap, 1'b0}, ack); chk("R1 wrong addr nack", ack, 0);
        send_byte(8'h24, ack); send_byte(8'h77, ack); chk("R1 ignored byte nack", ack, 0);
        bus_stop(); tick(4);

        // R12: repeated start during write data restarts address phase
        bus_start();
        send_byte(dev(0), ack); send_byte(8'h30, ack);
        exp_q.push_back({4'hB, 8'h30, 8'h11});
        send_byte(8'h11, ack);
        bus_rstart();
        send_byte(dev(0), ack); chk("R12 restart addr ack", ack, 1);
        send_byte(8'h40, ack);
        exp_q.push_back({4'hB, 8'h40, 8'h22});
        send_byte(8'h22, ack);
        bus_stop(); tick(4);

        // R2: strap codes
        for (int s = 1; s < 4; s++) begin
            logic [7:0] old_dev;
            old_dev = dev(0);
            strap = 2'(s); tick(4);
            wbuf[0] = 8'(s); do_write(8'h01, 1);
            bus_start();
            send_byte(old_dev, ack); chk("R2 old address refused", ack, 0);
            bus_stop(); tick(4);
        end

        // R11: hardware run low
        hw_run = 0; r0 = re_cnt; tick(4);
        bus_start();
        send_byte(dev(0), ack); chk("R11 addr nack", ack, 0);
        send_byte(8'h01, ack); send_byte(8'h99, ack);
        bus_stop(); tick(4);
        chk("R11 no mem_re", re_cnt - r0, 0);
        hw_run = 1; tick(4);

        chk("R5 all expected writes seen", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule